// File: doc/BRIEF.md
# Stored-Frame Replay Controller

This controller sequences a memory-based traffic test on a received Ethernet byte stream. When the test is enabled it copies the bytes of one incoming frame into an external memory FIFO. Each byte is stored with a tag bit that marks the final byte of the frame. It then starts an external millisecond timer and idles until that timer reports expiry.

After the timer expires, the controller replays the memory contents into a pair of transmit FIFOs, one stored frame at a time. A frame may begin only when the transmit side reports that one of its FIFOs is completely empty. Reading pauses whenever the transmit side is full. Frames that arrive during the replay are appended to the same memory, so they are replayed as well.

The test finishes when the memory and both transmit FIFOs are empty at the moment a new frame could start. The controller then signals completion for one clock. Removing the enable in any state cancels all strobes at once and returns the controller to idle.

Top module: `frame_replay_ctrl`

## Requirements
- R1: While the enable is low, or in the first cycle after it rises from idle, no memory write, memory read or timer start occurs; in idle every strobe is 0.
- R2: In the capture phase, each valid received byte is written to memory as a word whose bit 8 is the end-of-frame flag and whose bits 7:0 are the byte. Writing the flagged byte raises timer_start for that cycle, with timer_ms equal to cfg_wait_ms, and moves the controller to the wait phase.
- R3: In the wait phase, received bytes are not written and memory is not read. A high timer_done moves the controller to the frame-start check.
- R4: In the frame-start check no memory read occurs. Replay of a frame begins in the next cycle only if tx_avail is high and mem_empty is low.
- R5: During frame replay, mem_rd is high exactly when tx_full and mem_empty are both low. tx_wr equals mem_rd, and tx_data equals bits 7:0 of mem_rdata.
- R6: Reading a word whose bit 8 is set ends the frame and returns the controller to the frame-start check. tx_avail has no effect while a frame is in progress.
- R7: In the frame-start and replay states, each valid received byte is written to memory.
- R8: In the frame-start check, with mem_empty and tx_empty both high, the controller enters the done state. test_done is high during the first cycle in that state only.
- R9: When cmd_en is low, mem_wr, mem_rd and tx_wr are low in the same cycle, and the controller is back in idle in the next cycle.
- R10: Synchronous reset puts the controller in idle with every output strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_en | input | 1 | Test enable |
| rx_data | input | DW | Received byte |
| rx_valid | input | 1 | rx_data holds a new byte |
| rx_last | input | 1 | Current byte ends its frame |
| cfg_wait_ms | input | MSW | Wait duration in milliseconds |
| timer_start | output | 1 | Load and start the external timer |
| timer_ms | output | MSW | Duration presented to the timer |
| timer_done | input | 1 | External timer expired |
| mem_wr | output | 1 | Memory FIFO push |
| mem_wdata | output | DW+1 | Pushed word: {end flag, byte} |
| mem_rd | output | 1 | Memory FIFO pop |
| mem_rdata | input | DW+1 | Head word of the memory FIFO |
| mem_empty | input | 1 | Memory FIFO holds no word |
| tx_full | input | 1 | Transmit side cannot accept a byte |
| tx_avail | input | 1 | At least one transmit FIFO is completely empty |
| tx_empty | input | 1 | Both transmit FIFOs are empty |
| tx_wr | output | 1 | Transmit byte strobe |
| tx_data | output | DW | Transmit byte |
| test_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on the memory FIFO presenting its head word on mem_rdata whenever mem_empty is low, in show-ahead fashion. They also rely on the status inputs changing only between clock edges. The bench changes every input once per cycle on the falling edge and reads the outputs shortly afterwards. A mem_rdata word is offered only in cycles where mem_empty is low, and rx_last is raised only together with rx_valid, as a real receive stream would.

// File: rtl/frame_replay_ctrl.sv
module frame_replay_ctrl #(
  parameter int DW  = 8,
  parameter int MSW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_en,
  input  logic [DW-1:0]  rx_data,
  input  logic           rx_valid,
  input  logic           rx_last,
  input  logic [MSW-1:0] cfg_wait_ms,
  output logic           timer_start,
  output logic [MSW-1:0] timer_ms,
  input  logic           timer_done,
  output logic           mem_wr,
  output logic [DW:0]    mem_wdata,
  output logic           mem_rd,
  input  logic [DW:0]    mem_rdata,
  input  logic           mem_empty,
  input  logic           tx_full,
  input  logic           tx_avail,
  input  logic           tx_empty,
  output logic           tx_wr,
  output logic [DW-1:0]  tx_data,
  output logic           test_done
);

  typedef enum logic [2:0] {S_IDLE, S_STORE, S_WAIT, S_START, S_READ, S_DONE} st_t;
  st_t state, nxt;
  logic done_q;

  wire replaying = (state == S_START) || (state == S_READ);
  wire finish    = (state == S_START) && mem_empty && tx_empty;

  assign mem_wr      = cmd_en && rx_valid && ((state == S_STORE) || replaying);
  assign mem_wdata   = {rx_last, rx_data};
  assign mem_rd      = cmd_en && (state == S_READ) && !tx_full && !mem_empty;
  assign tx_wr       = mem_rd;
  assign tx_data     = mem_rdata[DW-1:0];
  assign timer_start = cmd_en && (state == S_STORE) && rx_valid && rx_last;
  assign timer_ms    = cfg_wait_ms;
  assign test_done   = done_q;

  always_comb begin
    nxt = state;
    if (!cmd_en) nxt = S_IDLE;
    else
      case (state)
        S_IDLE:  nxt = S_STORE;
        S_STORE: if (timer_start) nxt = S_WAIT;
        S_WAIT:  if (timer_done) nxt = S_START;
        S_START: if (finish) nxt = S_DONE;
                 else if (tx_avail && !mem_empty) nxt = S_READ;
        S_READ:  if (mem_rd && mem_rdata[DW]) nxt = S_START;
        S_DONE:  nxt = S_DONE;
        default: nxt = S_IDLE;
      endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      done_q <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= (state != S_DONE) && (nxt == S_DONE);
    end
  end

  p_no_read_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (!tx_full && !mem_empty));
  p_quiet_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> (!mem_wr && !mem_rd));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    test_done |=> !test_done);
  p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
    test_done |-> $past(mem_empty && tx_empty && cmd_en));
  p_enable_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_en |-> (!mem_wr && !mem_rd && !tx_wr));
  p_drop_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_en |=> (state == S_IDLE));
  p_timer_then_wait_r2: assert property (@(posedge clk) disable iff (rst)
    timer_start |=> (state == S_WAIT || !$past(cmd_en)));

endmodule

// File: tb/frame_replay_ctrl_test.sv
`timescale 1ns/1ps
module frame_replay_ctrl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cmd_en, rx_valid, rx_last, timer_done, mem_empty, tx_full, tx_avail, tx_empty;
  logic [7:0] rx_data;
  logic [15:0] cfg_wait_ms;
  logic [8:0] mem_rdata;
  logic timer_start, mem_wr, mem_rd, tx_wr, test_done;
  logic [15:0] timer_ms;
  logic [8:0] mem_wdata;
  logic [7:0] tx_data;
  int checks = 0, fails = 0;

  frame_replay_ctrl #(.DW(8), .MSW(16)) uut (
    .clk(clk), .rst(rst), .cmd_en(cmd_en), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_last(rx_last), .cfg_wait_ms(cfg_wait_ms), .timer_start(timer_start),
    .timer_ms(timer_ms), .timer_done(timer_done), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_empty(mem_empty), .tx_full(tx_full),
    .tx_avail(tx_avail), .tx_empty(tx_empty), .tx_wr(tx_wr), .tx_data(tx_data),
    .test_done(test_done));

  // {en,rx_valid,rx_last,timer_done,mem_empty,tx_full,tx_avail,tx_empty,rd_last | wr,rd,tstart,done}
  localparam logic [12:0] VEC [0:17] = '{
    13'b0_0_0_0_0_0_0_0_0_0_0_0_0,  // R1 idle
    13'b1_1_0_0_0_0_0_0_0_0_0_0_0,  // R1 enable cycle, no write
    13'b1_1_0_0_0_0_0_0_0_1_0_0_0,  // R2 capture
    13'b1_0_0_0_0_0_0_0_0_0_0_0_0,  // R2 gap
    13'b1_1_1_0_0_0_0_0_0_1_0_1_0,  // R2 last byte, timer start
    13'b1_1_0_0_0_0_0_0_0_0_0_0_0,  // R3 wait ignores rx
    13'b1_0_0_1_0_0_0_0_0_0_0_0_0,  // R3 timer done
    13'b1_1_0_0_0_0_0_0_0_1_0_0_0,  // R7 buffer during start check
    13'b1_0_0_0_0_0_1_0_0_0_0_0_0,  // R4 start check, no read
    13'b1_0_0_0_0_1_0_0_0_0_0_0_0,  // R5 full stalls
    13'b1_0_0_0_0_0_0_0_0_0_1_0_0,  // R5 read
    13'b1_1_0_0_0_0_0_0_1_1_1_0_0,  // R6 last word, avail low ignored
    13'b1_0_0_0_1_0_0_0_0_0_0_0_0,  // R8 not yet drained
    13'b1_0_0_0_1_0_0_1_0_0_0_0_0,  // R8 drained
    13'b1_0_0_0_0_0_0_0_0_0_0_0_1,  // R8 pulse
    13'b1_0_0_0_0_0_0_0_0_0_0_0_0,  // R8 pulse ends
    13'b0_0_0_0_0_0_0_0_0_0_0_0_0,  // R9 drop
    13'b0_0_0_0_0_0_0_0_0_0_0_0_0   // R9 idle again
  };

  function automatic string tag(input int i);
    case (i)
      0, 1: return "R1";
      2, 3, 4: return "R2";
      5, 6: return "R3";
      7: return "R7";
      8: return "R4";
      9, 10: return "R5";
      11: return "R6";
      12, 13, 14, 15: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] v);
    {cmd_en, rx_valid, rx_last, timer_done, mem_empty, tx_full, tx_avail, tx_empty, mem_rdata[8]} = v;
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; drive(9'h0); rx_data = 8'h00; mem_rdata = 9'h000; cfg_wait_ms = 16'd250;
    repeat (3) @(negedge clk);
    #1 check("R10", {12'h0, mem_wr, mem_rd, timer_start, test_done}, 16'h0);
    rst = 1'b0;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      rx_data = 8'h30 + 8'(i);
      mem_rdata[7:0] = 8'hA0 + 8'(i);
      drive(VEC[i][12:4]);
      #1 check(tag(i), {12'h0, mem_wr, mem_rd, timer_start, test_done}, {12'h0, VEC[i][3:0]});
    end

    // R10: reset in the middle of capture
    @(negedge clk); drive(9'b1_0_0_0_0_0_0_0_0);
    @(negedge clk); drive(9'b1_1_0_0_0_0_0_0_0);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; drive(9'b1_1_0_0_0_0_0_0_0);
    #1 check("R10", {15'h0, mem_wr}, 16'h0);

    // R2: word layout and timer duration
    @(negedge clk); rx_data = 8'h5C; drive(9'b1_1_1_0_0_0_0_0_0);
    #1 check("R2", {7'h0, mem_wdata}, 16'h015C);
    check("R2", timer_ms, 16'd250);

    // R3 then R4: into replay
    @(negedge clk); drive(9'b1_0_0_1_0_0_0_0_0);
    @(negedge clk); drive(9'b1_0_0_0_0_0_1_0_0);
    #1 check("R4", {15'h0, mem_rd}, 16'h0);

    // R5: read with empty memory stalls, then byte passes through
    @(negedge clk); drive(9'b1_0_0_0_1_0_0_0_0);
    #1 check("R5", {14'h0, mem_rd, tx_wr}, 16'h0);
    @(negedge clk); drive(9'b1_0_0_0_0_0_0_0_0); mem_rdata = 9'h0E7;
    #1 check("R5", {6'h0, tx_wr, mem_rd, tx_data}, 16'h03E7);

    // R9: dropping the enable mid-frame
    @(negedge clk); drive(9'b0_0_0_0_0_0_0_0_0);
    #1 check("R9", {13'h0, mem_rd, tx_wr, mem_wr}, 16'h0);
    @(negedge clk); drive(9'b1_1_0_0_0_0_0_0_0);
    #1 check("R9", {15'h0, mem_wr}, 16'h0);
    @(negedge clk); drive(9'b0_0_0_0_0_0_0_0_0);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule